// File: doc/BRIEF.md
# Clustered Fast Core-to-Core Interrupt Unit

This block lets any core raise a fast interrupt on any other core in a system built from clusters of cores. Each core owns two request write ports: a local one, which always reaches a core inside the writer's own cluster, and a global one, which carries an explicit destination cluster. A request word selects the destination core and one of four request kinds: deliver now, deliver now without waking, deliver after a countdown, or cancel a countdown still in flight.

Each core has a pending flag that drives its fast-interrupt line, plus a wake flag that stands in for the power-management wake signal. Software clears the pending flag by writing one to bit 0 of that core's status port. Each core also holds a countdown reload value. A delayed request aimed at a core loads that core's reload value, and the core becomes pending when the count runs out.

Top module: `fipi_unit`

## Requirements
- R1: In a request word, bits [7:0] are the destination core within its cluster, bits [23:16] the destination cluster and bits [29:28] the kind. The destination core index is cluster*CORES_PER_CL+core. A word that names a core or cluster out of range, or that has any of bits [31:30], [27:24] or [15:8] set, is dropped.
- R2: A local request ignores bits [23:16] and targets the writer's own cluster. When one core writes both ports in the same cycle, the local write is used.
- R3: Kind 0 (now) sets the target's pending and wake flags on the clock edge that captures the write.
- R4: Kind 3 (quiet) sets pending but does not raise wake. wake_o is never high for a core whose pending_o is low.
- R5: fiq_o equals pending_o for every core.
- R6: A status write with bit 0 equal to 1 clears that core's pending and wake flags on the next edge. A status write with bit 0 equal to 0 has no effect.
- R7: Kind 2 (later) loads the target's countdown from the target's reload value D, written through cd_we_i/cd_wdata_i. The target's pending and wake flags rise D+1 edges after the edge that captured the request.
- R8: Kind 1 (cancel) stops a countdown still running on the target, so no delivery follows. It leaves pending unchanged.
- R9: When a set of pending (from a request or from an expiring countdown) and a status clear reach one core in the same cycle, the set wins.
- R10: When several writers target one core in the same cycle, only the request of the lowest-numbered writer takes effect.
- R11: After reset, all pending, wake and countdown state is clear and all reload values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_we_i | input | N | Local request write strobe per core |
| glb_we_i | input | N | Global request write strobe per core |
| req_wdata_i | input | 32*N | Request word per core |
| st_we_i | input | N | Status write strobe per core |
| st_wdata_i | input | N | Bit 0 of the status write per core |
| cd_we_i | input | N | Reload value write strobe per core |
| cd_wdata_i | input | CNT_W*N | Reload value per core |
| pending_o | output | N | Pending flag per core |
| wake_o | output | N | Wake flag per core |
| fiq_o | output | N | Fast-interrupt line per core |

## Verification
The bench sends a local request whose cluster field points elsewhere. A design that decodes that field would interrupt the wrong core. It checks a delayed delivery on both sides of its expected edge, and with a zero reload, which exposes off-by-one countdown logic. It also checks a cancel sent after the countdown has started; if the cancel were ignored, a late interrupt would appear.

The bench drives a clear and a new request to one core in the same cycle, which catches a design that lets the clear win. Two writers aim at one core in the same cycle, in both orders, which catches the wrong priority. Malformed and out-of-range words are also sent, and a design that wrapped the index would interrupt a core that nobody named.

// File: rtl/fipi_pkg.sv
package fipi_pkg;
  typedef enum logic [1:0] {
    REQ_NOW    = 2'd0,
    REQ_CANCEL = 2'd1,
    REQ_LATER  = 2'd2,
    REQ_QUIET  = 2'd3
  } req_kind_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/fipi_req_decode.sv
module fipi_req_decode
  import fipi_pkg::*;
#(
  parameter int unsigned NUM_CL       = 2,
  parameter int unsigned CORES_PER_CL = 2,
  parameter int unsigned SELF_CL      = 0,
  localparam int unsigned N           = NUM_CL * CORES_PER_CL
) (
  input  logic              loc_we_i,
  input  logic              glb_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              valid_o,
  output logic [N-1:0]      tgt_o,
  output req_kind_e         kind_o
);
  logic [7:0]  cpu_f, cl_f;
  logic        rsv_ok, in_range;
  int unsigned idx;

  always_comb begin
    cpu_f    = wdata_i[7:0];
    cl_f     = loc_we_i ? 8'(SELF_CL) : wdata_i[23:16];
    rsv_ok   = (wdata_i[31:30] == '0) && (wdata_i[27:24] == '0) && (wdata_i[15:8] == '0);
    in_range = (32'(cpu_f) < CORES_PER_CL) && (32'(cl_f) < NUM_CL);
    valid_o  = (loc_we_i | glb_we_i) & rsv_ok & in_range;
    idx      = 32'(cl_f) * CORES_PER_CL + 32'(cpu_f);
    tgt_o    = valid_o ? (N'(1) << idx) : '0;
    kind_o   = req_kind_e'(wdata_i[29:28]);
  end
endmodule

// File: rtl/fipi_target.sv
module fipi_target
  import fipi_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  req_kind_e        req_kind_i,
  input  logic             clr_i,
  input  logic             cd_we_i,
  input  logic [CNT_W-1:0] cd_wdata_i,
  output logic             pending_o,
  output logic             wake_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             armed_q, pend_q, wake_q, expire;
  logic             hit_now, hit_quiet, hit_later, hit_cancel;

  assign expire     = armed_q && (cnt_q == '0);
  assign hit_now    = req_valid_i && (req_kind_i == REQ_NOW);
  assign hit_quiet  = req_valid_i && (req_kind_i == REQ_QUIET);
  assign hit_later  = req_valid_i && (req_kind_i == REQ_LATER);
  assign hit_cancel = req_valid_i && (req_kind_i == REQ_CANCEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (cd_we_i) reload_q <= cd_wdata_i;

      if (hit_later) begin
        armed_q <= 1'b1;
        cnt_q   <= reload_q;
      end else if (hit_cancel || expire) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q - 1'b1;
      end

      // a set beats a clear in the same cycle
      if (hit_now || hit_quiet || expire) pend_q <= 1'b1;
      else if (clr_i)                     pend_q <= 1'b0;

      if (hit_now || expire) wake_q <= 1'b1;
      else if (clr_i)        wake_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign wake_o    = wake_q;
  assign armed_o   = armed_q;
endmodule

// File: rtl/fipi_unit.sv
module fipi_unit
  import fipi_pkg::*;
#(
  parameter int unsigned NUM_CL       = 2,
  parameter int unsigned CORES_PER_CL = 2,
  parameter int unsigned CNT_W        = 16,
  localparam int unsigned N           = NUM_CL * CORES_PER_CL
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         loc_we_i,
  input  logic [N-1:0]         glb_we_i,
  input  logic [WORD_W*N-1:0]  req_wdata_i,
  input  logic [N-1:0]         st_we_i,
  input  logic [N-1:0]         st_wdata_i,
  input  logic [N-1:0]         cd_we_i,
  input  logic [CNT_W*N-1:0]   cd_wdata_i,
  output logic [N-1:0]         pending_o,
  output logic [N-1:0]         wake_o,
  output logic [N-1:0]         fiq_o
);
  logic      [N-1:0] src_valid;
  logic      [N-1:0] src_tgt [N];
  req_kind_e         src_kind [N];
  logic      [N-1:0] sel_valid;
  req_kind_e         sel_kind [N];
  logic      [N-1:0] armed_w;

  for (genvar s = 0; s < N; s++) begin : g_src
    fipi_req_decode #(
      .NUM_CL(NUM_CL), .CORES_PER_CL(CORES_PER_CL), .SELF_CL(s / CORES_PER_CL)
    ) u_dec (
      .loc_we_i (loc_we_i[s]),
      .glb_we_i (glb_we_i[s]),
      .wdata_i  (req_wdata_i[s*WORD_W +: WORD_W]),
      .valid_o  (src_valid[s]),
      .tgt_o    (src_tgt[s]),
      .kind_o   (src_kind[s])
    );
  end

  for (genvar t = 0; t < N; t++) begin : g_tgt
    // lowest writer index wins: scan downward so it is assigned last
    always_comb begin
      sel_valid[t] = 1'b0;
      sel_kind[t]  = REQ_NOW;
      for (int s = N - 1; s >= 0; s--) begin
        if (src_valid[s] && src_tgt[s][t]) begin
          sel_valid[t] = 1'b1;
          sel_kind[t]  = src_kind[s];
        end
      end
    end

    fipi_target #(.CNT_W(CNT_W)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (sel_valid[t]),
      .req_kind_i  (sel_kind[t]),
      .clr_i       (st_we_i[t] & st_wdata_i[t]),
      .cd_we_i     (cd_we_i[t]),
      .cd_wdata_i  (cd_wdata_i[t*CNT_W +: CNT_W]),
      .pending_o   (pending_o[t]),
      .wake_o      (wake_o[t]),
      .armed_o     (armed_w[t])
    );
  end

  assign fiq_o = pending_o;
endmodule

// File: rtl/fipi_unit_chk.sv
module fipi_unit_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] loc_we_i,
  input logic [N-1:0] glb_we_i,
  input logic [N-1:0] st_we_i,
  input logic [N-1:0] st_wdata_i,
  input logic [N-1:0] pending_o,
  input logic [N-1:0] wake_o,
  input logic [N-1:0] fiq_o,
  input logic [N-1:0] armed_w
);
  assert_fiq_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == pending_o);

  assert_wake_needs_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o & ~pending_o) == '0);

  for (genvar i = 0; i < N; i++) begin : g_core
    // R3 R7: pending only rises after a request write or a running countdown
    assert_rise_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pending_o[i]) |-> $past(((|loc_we_i) || (|glb_we_i)) || armed_w[i]));

    assert_fall_needs_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pending_o[i]) |-> $past(st_we_i[i] & st_wdata_i[i]));
  end
endmodule

bind fipi_unit fipi_unit_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .loc_we_i   (loc_we_i),
  .glb_we_i   (glb_we_i),
  .st_we_i    (st_we_i),
  .st_wdata_i (st_wdata_i),
  .pending_o  (pending_o),
  .wake_o     (wake_o),
  .fiq_o      (fiq_o),
  .armed_w    (armed_w)
);

// File: tb/fipi_unit_bench.sv
module fipi_unit_bench;
  localparam int N     = 4;
  localparam int CNT_W = 16;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [N-1:0]       loc_we_i = '0, glb_we_i = '0, st_we_i = '0, st_wdata_i = '0, cd_we_i = '0;
  logic [32*N-1:0]    req_wdata_i = '0;
  logic [CNT_W*N-1:0] cd_wdata_i = '0;
  logic [N-1:0]       pending_o, wake_o, fiq_o;

  fipi_unit #(.NUM_CL(2), .CORES_PER_CL(2), .CNT_W(CNT_W)) u_fipi_unit (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    int          at;
    logic [N-1:0] p;
    logic [N-1:0] w;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0, checks = 0, errors = 0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: pop expectations due this cycle
  always @(negedge clk_i) begin
    while (exp_q.size() > 0 && exp_q[0].at == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pending_o !== e.p || wake_o !== e.w || fiq_o !== e.p) begin
        errors++;
        $display("FAIL %s @%0d: pend=%b wake=%b fiq=%b expected pend=%b wake=%b",
                 e.tag, cyc, pending_o, wake_o, fiq_o, e.p, e.w);
      end
    end
  end

  task automatic expect_in(input int d, input logic [N-1:0] p, input logic [N-1:0] w,
                           input string tag);
    exp_t e;
    e.at = cyc + d; e.p = p; e.w = w; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] word(input int kind, input int cl, input int cpu);
    return (32'(kind) << 28) | (32'(cl) << 16) | 32'(cpu);
  endfunction

  task automatic send(input int s, input bit glob, input logic [31:0] w);
    if (glob) glb_we_i[s] = 1'b1; else loc_we_i[s] = 1'b1;
    req_wdata_i[s*32 +: 32] = w;
  endtask

  task automatic status(input int c, input bit b0);
    st_we_i[c] = 1'b1; st_wdata_i[c] = b0;
  endtask

  task automatic reload(input int c, input int v);
    cd_we_i[c] = 1'b1; cd_wdata_i[c*CNT_W +: CNT_W] = CNT_W'(v);
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      loc_we_i = '0; glb_we_i = '0; st_we_i = '0; st_wdata_i = '0; cd_we_i = '0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_in(1, 4'b0000, 4'b0000, "R11 reset state");
    tick();

    // R2: local ignores cluster field -> core 1
    send(0, 0, word(0, 1, 1));
    expect_in(1, 4'b0010, 4'b0010, "R2 R3 local now");
    tick();

    status(1, 1'b0);
    expect_in(1, 4'b0010, 4'b0010, "R6 write zero no effect");
    tick();
    status(1, 1'b1);
    expect_in(1, 4'b0000, 4'b0000, "R6 w1c clears");
    tick();

    send(0, 1, word(0, 1, 0));
    expect_in(1, 4'b0100, 4'b0100, "R1 global to core 2");
    tick();
    send(1, 1, word(3, 1, 1));
    expect_in(1, 4'b1100, 4'b0100, "R4 quiet no wake");
    tick();

    // R9: clear plus new request on core 2 in the same cycle
    status(2, 1'b1); status(3, 1'b1);
    send(0, 1, word(0, 1, 0));
    expect_in(1, 4'b0100, 4'b0100, "R9 set beats clear");
    tick();
    status(2, 1'b1);
    expect_in(1, 4'b0000, 4'b0000, "R6 clear core 2");
    tick();

    // R7: reload 3, delivery 4 edges after capture
    reload(1, 3);
    tick();
    send(0, 0, word(2, 0, 1));
    expect_in(4, 4'b0000, 4'b0000, "R7 not yet delivered");
    expect_in(5, 4'b0010, 4'b0010, "R7 delayed delivery");
    tick(6);
    status(1, 1'b1);
    expect_in(1, 4'b0000, 4'b0000, "R6 clear core 1");
    tick();

    // R8: cancel a running countdown
    reload(2, 4);
    tick();
    send(3, 1, word(2, 1, 0));
    tick();
    send(3, 1, word(1, 1, 0));
    expect_in(8, 4'b0000, 4'b0000, "R8 cancel stops delivery");
    tick(9);

    // R1: malformed or out of range
    send(0, 1, word(0, 2, 0));
    expect_in(1, 4'b0000, 4'b0000, "R1 cluster out of range");
    tick();
    send(0, 0, word(0, 0, 2));
    expect_in(1, 4'b0000, 4'b0000, "R1 core out of range");
    tick();
    send(0, 1, word(0, 1, 0) | 32'h0000_0100);
    expect_in(1, 4'b0000, 4'b0000, "R1 reserved bit set");
    tick();

    // R10: lowest writer wins
    reload(3, 10);
    tick();
    send(0, 1, word(2, 1, 1));
    send(1, 1, word(0, 1, 1));
    expect_in(1, 4'b0000, 4'b0000, "R10 writer 0 later beats writer 1 now");
    tick();
    send(2, 0, word(1, 0, 1));
    expect_in(12, 4'b0000, 4'b0000, "R8 R10 cancel of winner");
    tick(13);
    send(0, 1, word(0, 1, 1));
    send(1, 1, word(2, 1, 1));
    expect_in(1, 4'b1000, 4'b1000, "R10 writer 0 now wins");
    tick();
    status(3, 1'b1);
    expect_in(1, 4'b0000, 4'b0000, "R6 clear core 3");
    tick();

    // R7: zero reload
    send(1, 1, word(2, 0, 0));
    expect_in(1, 4'b0000, 4'b0000, "R7 zero reload edge 1");
    expect_in(2, 4'b0001, 4'b0001, "R7 zero reload edge 2");
    tick(3);

    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL monitor: %0d expectations left, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule